// File: doc/BRIEF.md
# Wide Shift-Left Unit with Flags

This execution unit carries out one CPU instruction: a logical left shift of a 64-bit value built from two 32-bit registers. The high accumulator supplies bits 63:32 and the low product register supplies bits 31:0. The shift amount comes from the six low bits of a 16-bit temporary register. The shifted value is split back into the same two halves. The unit also produces negative, zero and carry flags.

The decoder presents an instruction word with `in_valid`, together with the current register contents and a flag that says a repeat prefix is pending. The unit only acts when the word equals the instruction's 16-bit opcode. On the following cycle it raises `wr_en` for exactly one cycle, with both halves and the three flags valid on the write-back pins. The rest of the pipeline qualifies its register-file and status-flag writes with that pulse, and leaves every other flag alone.

If a repeat prefix was pending, the unit also pulses `rptc_clr` in the same cycle. The repeat counter is then cleared and the instruction runs once only. The input side has valid/ready signalling, but `in_ready` is always high: a new instruction may be offered on every cycle and is never held back.

Top module: `wide_shl_unit`

## Requirements
- R1: An input cycle with `in_valid` high and `in_opcode` equal to 16'h5652 produces `wr_en` high on the next cycle, for one cycle. Any other input cycle produces no `wr_en` and leaves `wr_acc`/`wr_p` unchanged.
- R2: After a write, {`wr_acc`,`wr_p`} equals {`in_acc`,`in_p`} shifted left by `in_t[5:0]` and truncated to 64 bits. `wr_acc` holds result bits 63:32 and `wr_p` holds bits 31:0.
- R3: Bits 15:6 of `in_t` have no effect on any output.
- R4: The result bit positions below the shift amount are zero. In particular, `wr_p` is zero for any amount of 32 or more.
- R5: `wr_c` equals operand bit (64 − amount) for amounts 1..63. For amount 0, `wr_c` is 0 and both halves come back unchanged.
- R6: `wr_n` equals result bit 63, which is bit 31 of `wr_acc`.
- R7: `wr_z` is 1 exactly when all 64 result bits are zero, taking both halves into account.
- R8: When `in_rpt` is high with a matching instruction, `rptc_clr` pulses in the same cycle as `wr_en`, and that instruction gives exactly one `wr_en` pulse. Without a match, `rptc_clr` stays low.
- R9: `in_ready` is always high. The write-back follows acceptance by exactly one cycle, and `wr_en` falls in the next cycle unless a new matching instruction arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and operands are present |
| in_ready | output | 1 | Always high; the unit never stalls |
| in_opcode | input | 16 | Instruction word to match |
| in_rpt | input | 1 | A repeat prefix precedes this instruction |
| in_acc | input | 32 | High half of the operand (accumulator) |
| in_p | input | 32 | Low half of the operand (product register) |
| in_t | input | 16 | Temporary register; bits 5:0 give the shift amount |
| wr_en | output | 1 | One-cycle write-back strobe |
| wr_acc | output | 32 | New accumulator value |
| wr_p | output | 32 | New product register value |
| wr_n | output | 1 | New negative flag |
| wr_z | output | 1 | New zero flag |
| wr_c | output | 1 | New carry flag |
| rptc_clr | output | 1 | One-cycle request to clear the repeat counter |

## Verification
Every shift amount from 0 to 63 is applied to several operands:
- A value with only bits 63 and 0 set shows where the carry is taken from and where the low bit lands.
- An all-ones value shows the zero fill and the carry staying at one.
- Two irregular values catch stage or half swaps in the shifter.
- A zero operand drives the zero flag, and a lone bit 0 shifted by 63 sets the negative flag.

The same sweep is then repeated with bits 15:6 of the count forced high, which separates a correct count mask from a wider one. Foreign opcodes and prefixed instructions show that the match gates the write strobe and the repeat-counter clear.

// File: rtl/wshl_pkg.sv
package wshl_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
  } wshl_flags_t;

  localparam logic [15:0] WSHL_OPCODE = 16'h5652;

endpackage

// File: rtl/wshl_decode.sv
module wshl_decode #(
  parameter int          OPC_W  = 16,
  parameter logic [OPC_W-1:0] OPCODE = 16'h5652
) (
  input  logic             in_valid,
  input  logic [OPC_W-1:0] in_opcode,
  input  logic             in_rpt,
  output logic             fire,
  output logic             rpt_clear
);
  always_comb begin
    fire      = in_valid && (in_opcode == OPCODE);
    rpt_clear = fire && in_rpt;
  end
endmodule

// File: rtl/wshl_shifter.sv
module wshl_shifter #(
  parameter int FULL_W = 64,
  parameter int CNT_W  = $clog2(FULL_W)
) (
  input  logic [FULL_W-1:0] operand,
  input  logic [CNT_W-1:0]  amt,
  output logic [FULL_W-1:0] result,
  output logic              carry
);
  // One extra guard bit on top collects the last bit pushed out.
  logic [FULL_W:0] stage [0:CNT_W];

  assign stage[0] = {1'b0, operand};

  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    localparam int SH = 1 << i;
    assign stage[i+1] = amt[i] ? {stage[i][FULL_W-SH:0], {SH{1'b0}}} : stage[i];
  end

  assign result = stage[CNT_W][FULL_W-1:0];
  assign carry  = stage[CNT_W][FULL_W];
endmodule

// File: rtl/wshl_flags.sv
module wshl_flags
  import wshl_pkg::*;
#(
  parameter int FULL_W = 64
) (
  input  logic [FULL_W-1:0] result,
  input  logic              carry,
  output wshl_flags_t       flags
);
  always_comb begin
    flags.n = result[FULL_W-1];
    flags.z = ~|result;
    flags.c = carry;
  end
endmodule

// File: rtl/wide_shl_unit.sv
module wide_shl_unit
  import wshl_pkg::*;
#(
  parameter int               HALF_W = 32,
  parameter int               T_W    = 16,
  parameter int               OPC_W  = 16,
  parameter logic [OPC_W-1:0] OPCODE = WSHL_OPCODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic              in_rpt,
  input  logic [HALF_W-1:0] in_acc,
  input  logic [HALF_W-1:0] in_p,
  input  logic [T_W-1:0]    in_t,
  output logic              wr_en,
  output logic [HALF_W-1:0] wr_acc,
  output logic [HALF_W-1:0] wr_p,
  output logic              wr_n,
  output logic              wr_z,
  output logic              wr_c,
  output logic              rptc_clr
);
  localparam int FULL_W = 2 * HALF_W;
  localparam int CNT_W  = $clog2(FULL_W);

  logic              fire;
  logic              rpt_clear;
  logic [FULL_W-1:0] sh_result;
  logic              sh_carry;
  wshl_flags_t       nxt_flags;
  wshl_flags_t       flags_q;
  logic              unused_t_hi;

  assign in_ready    = 1'b1;
  assign unused_t_hi = ^in_t[T_W-1:CNT_W];

  wshl_decode #(.OPC_W(OPC_W), .OPCODE(OPCODE)) u_dec (
    .in_valid  (in_valid),
    .in_opcode (in_opcode),
    .in_rpt    (in_rpt),
    .fire      (fire),
    .rpt_clear (rpt_clear)
  );

  wshl_shifter #(.FULL_W(FULL_W), .CNT_W(CNT_W)) u_shift (
    .operand (({in_acc, in_p})),
    .amt     (in_t[CNT_W-1:0]),
    .result  (sh_result),
    .carry   (sh_carry)
  );

  wshl_flags #(.FULL_W(FULL_W)) u_flags (
    .result (sh_result),
    .carry  (sh_carry),
    .flags  (nxt_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en    <= 1'b0;
      rptc_clr <= 1'b0;
      wr_acc   <= '0;
      wr_p     <= '0;
      flags_q  <= '0;
    end else begin
      wr_en    <= fire;
      rptc_clr <= rpt_clear;
      if (fire) begin
        wr_acc  <= sh_result[FULL_W-1:HALF_W];
        wr_p    <= sh_result[HALF_W-1:0];
        flags_q <= nxt_flags;
      end
    end
  end

  assign wr_n = flags_q.n;
  assign wr_z = flags_q.z;
  assign wr_c = flags_q.c;
endmodule

// File: rtl/wshl_checker.sv
module wshl_checker #(
  parameter int               HALF_W = 32,
  parameter int               T_W    = 16,
  parameter int               OPC_W  = 16,
  parameter logic [OPC_W-1:0] OPCODE = 16'h5652
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OPC_W-1:0]  in_opcode,
  input logic              in_rpt,
  input logic [HALF_W-1:0] in_acc,
  input logic [HALF_W-1:0] in_p,
  input logic [T_W-1:0]    in_t,
  input logic              wr_en,
  input logic [HALF_W-1:0] wr_acc,
  input logic [HALF_W-1:0] wr_p,
  input logic              wr_n,
  input logic              wr_z,
  input logic              wr_c,
  input logic              rptc_clr
);
  localparam int CNT_W = $clog2(2 * HALF_W);

  logic hit;
  assign hit = in_valid && (in_opcode == OPCODE);

  a_r1_write_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> wr_en);
  a_r1_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (!wr_en && $stable(wr_acc) && $stable(wr_p)));
  a_r4_low_half_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && in_t[CNT_W-1]) |=> (wr_p == '0));
  a_r5_zero_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && in_t[CNT_W-1:0] == '0) |=>
      (!wr_c && wr_acc == $past(in_acc) && wr_p == $past(in_p)));
  a_r6_negative: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_n == wr_acc[HALF_W-1]));
  a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_z == (wr_acc == '0 && wr_p == '0)));
  a_r8_rpt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && in_rpt) |=> rptc_clr);
  a_r8_clear_only_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    rptc_clr |-> wr_en);
  a_r9_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

bind wide_shl_unit wshl_checker #(
  .HALF_W(HALF_W), .T_W(T_W), .OPC_W(OPC_W), .OPCODE(OPCODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_opcode(in_opcode), .in_rpt(in_rpt), .in_acc(in_acc), .in_p(in_p),
  .in_t(in_t), .wr_en(wr_en), .wr_acc(wr_acc), .wr_p(wr_p), .wr_n(wr_n),
  .wr_z(wr_z), .wr_c(wr_c), .rptc_clr(rptc_clr)
);

// File: tb/sim_wide_shl_unit.sv
`timescale 1ns/1ps
module sim_wide_shl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_opcode = '0;
  logic        in_rpt = 1'b0;
  logic [31:0] in_acc = '0;
  logic [31:0] in_p = '0;
  logic [15:0] in_t = '0;
  logic        wr_en;
  logic [31:0] wr_acc;
  logic [31:0] wr_p;
  logic        wr_n, wr_z, wr_c, rptc_clr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [15:0] OPC = 16'h5652;

  always #2 clk = ~clk;

  wide_shl_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_rpt(in_rpt), .in_acc(in_acc), .in_p(in_p),
    .in_t(in_t), .wr_en(wr_en), .wr_acc(wr_acc), .wr_p(wr_p), .wr_n(wr_n),
    .wr_z(wr_z), .wr_c(wr_c), .rptc_clr(rptc_clr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Offer one instruction, then check the write-back one cycle later.
  task automatic run_op(input logic [15:0] opc, input logic [63:0] opnd,
                        input logic [15:0] t, input bit rpt);
    logic [127:0] wide;
    logic [63:0]  exp;
    logic [63:0]  prev;
    logic         exp_c;
    int           amt;
    bit           match;
    amt   = int'(t[5:0]);
    wide  = {64'd0, opnd} << amt;
    exp   = wide[63:0];
    exp_c = (amt == 0) ? 1'b0 : opnd[64 - amt];
    match = (opc == OPC);
    prev  = {wr_acc, wr_p};
    @(negedge clk);
    in_valid = 1'b1; in_opcode = opc; in_acc = opnd[63:32]; in_p = opnd[31:0];
    in_t = t; in_rpt = rpt;
    @(negedge clk);
    in_valid = 1'b0; in_rpt = 1'b0;
    if (match) begin
      chk(wr_en == 1'b1, "R1 write strobe", 64'(wr_en), 64'd1);
      chk({wr_acc, wr_p} == exp,
          (t[15:6] != 0) ? "R3 upper count bits ignored" : "R2 shifted value",
          {wr_acc, wr_p}, exp);
      if (amt != 0)
        chk(({wr_acc, wr_p} & ((64'd1 << amt) - 64'd1)) == 64'd0,
            "R4 zero fill", {wr_acc, wr_p}, exp);
      chk(wr_c == exp_c, "R5 carry", 64'(wr_c), 64'(exp_c));
      chk(wr_n == exp[63], "R6 negative", 64'(wr_n), 64'(exp[63]));
      chk(wr_z == (exp == 64'd0), "R7 zero", 64'(wr_z), 64'(exp == 64'd0));
      chk(rptc_clr == rpt, "R8 repeat clear", 64'(rptc_clr), 64'(rpt));
    end else begin
      chk(wr_en == 1'b0, "R1 no strobe on other opcode", 64'(wr_en), 64'd0);
      chk({wr_acc, wr_p} == prev, "R1 halves held", {wr_acc, wr_p}, prev);
      chk(rptc_clr == 1'b0, "R8 no clear on other opcode", 64'(rptc_clr), 64'd0);
    end
    @(negedge clk);
    chk(wr_en == 1'b0, "R9 single-cycle strobe", 64'(wr_en), 64'd0);
    chk(rptc_clr == 1'b0, "R8 executes once", 64'(rptc_clr), 64'd0);
  endtask

  initial begin
    logic [63:0] pats [0:3];
    pats[0] = 64'h8000_0000_0000_0001;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h0123_4567_89AB_CDEF;
    pats[3] = 64'hA5C3_0F96_5A3C_F069;
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0 && rptc_clr == 1'b0, "R1 reset strobes", 64'(wr_en), 64'd0);
    chk({wr_acc, wr_p} == 64'd0, "R2 reset halves", {wr_acc, wr_p}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready", 64'(in_ready), 64'd1);
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 64; a++)
        run_op(OPC, pats[p], 16'(a), 1'b0);
    for (int a = 0; a < 64; a++)
      run_op(OPC, pats[a % 4], 16'hFFC0 | 16'(a), 1'b0);
    run_op(OPC, 64'd0, 16'd17, 1'b0);
    run_op(OPC, 64'd1, 16'd63, 1'b0);
    run_op(OPC, 64'hFFFF_FFFF_0000_0000, 16'd32, 1'b0);
    run_op(OPC, 64'h0000_0000_FFFF_FFFF, 16'd33, 1'b0);
    run_op(OPC, 64'h1234_5678_9ABC_DEF0, 16'd5, 1'b1);
    run_op(16'h5653, 64'hDEAD_BEEF_0BAD_F00D, 16'd4, 1'b1);
    run_op(16'h0000, 64'h1111_2222_3333_4444, 16'd1, 1'b0);
    chk(in_ready == 1'b1, "R9 ready", 64'(in_ready), 64'd1);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule